// File: doc/BRIEF.md
# DMA Burst Address Stepper

This block generates the source-side and target-side byte addresses for each burst of one DMA transfer. A controller gives it a start pulse together with the two start addresses, a flag per side that chooses between a stepping and a fixed address, a flag per side that marks the address as external memory or as an on-chip peripheral, a burst-size code, a byte length and an alignment-override bit. All of these are captured by the start pulse. After that, each burst-complete strobe moves the transfer forward by one burst.

On every cycle the block presents the current source and target addresses, the number of bytes in the current burst and a done flag. The burst byte count is the smaller of the burst size and the bytes still remaining. That count is subtracted from the remaining length, and it is added to each side that steps. Unless the alignment override is set, the low address bits are cleared on output: three bits for external memory, two bits for peripherals. A fixed address, as for a peripheral FIFO port, stays constant through the whole transfer.

Top module: `dma_addr_stepper`

## Requirements
- R1: After reset, done is 1, burst_bytes is 0 and both addresses read 0.
- R2: burst_sel encodes the burst size as 00 = 8, 01 = 16, 10 = 32 and 11 = 32 bytes. While not done, burst_bytes equals the smaller of that size and the remaining length. While done, burst_bytes is 0.
- R3: A start pulse loads both addresses, the length and all per-transfer settings. The new values appear on the outputs in the next cycle. A start pulse takes priority over a burst_done strobe in the same cycle.
- R4: On each accepted burst_done, a side whose increment flag is 1 advances by the burst_bytes value shown in that cycle.
- R5: A side whose increment flag is 0 keeps its start address for the whole transfer.
- R6: Each accepted burst_done subtracts burst_bytes from the remaining length. done goes high once that length reaches zero, and a start with length 0 gives done at once.
- R7: While done is 1, burst_done has no effect on any output.
- R8: With the alignment override at 0, an address flagged as external memory is output with bits [2:0] forced to 0.
- R9: With the alignment override at 0, an address flagged as peripheral is output with bits [1:0] forced to 0.
- R10: With the alignment override at 1, both addresses are output unmasked, with byte resolution.
- R11: Addresses wrap modulo 2^32 with no error indication.
- R12: Changes on the setting inputs between start pulses do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new transfer |
| src_base | input | 32 | Source start address |
| trg_base | input | 32 | Target start address |
| src_step_en | input | 1 | Source advances per burst |
| trg_step_en | input | 1 | Target advances per burst |
| src_is_mem | input | 1 | Source is external memory (1) or peripheral (0) |
| trg_is_mem | input | 1 | Target is external memory (1) or peripheral (0) |
| burst_sel | input | 2 | Burst size code |
| xfer_len | input | 13 | Transfer length in bytes |
| byte_align | input | 1 | Disable low-bit forcing |
| burst_done | input | 1 | Current burst finished; step |
| src_addr | output | 32 | Current source address |
| trg_addr | output | 32 | Current target address |
| burst_bytes | output | 6 | Byte count of current burst |
| done | output | 1 | No bytes remain |

## Verification
The bench builds the block with its default widths: 32-bit addresses and a 13-bit length. With these widths, lengths up to 8191 bytes are reachable, which exercises long runs of 8-byte bursts and odd-sized tail bursts. Start addresses near 2^32 make the wrap-around of a stepping side observable within a few bursts. Random settings are mixed with directed cases: a length shorter than one burst, misaligned bases with the override clear and then set, and transfers where only one side steps.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
    localparam int BB_W = 6;

    typedef enum logic [1:0] {
        BSZ_8   = 2'b00,
        BSZ_16  = 2'b01,
        BSZ_32  = 2'b10,
        BSZ_32X = 2'b11
    } burst_code_e;

    function automatic logic [BB_W-1:0] burst_size(input logic [1:0] code);
        case (code)
            BSZ_8:   burst_size = 6'd8;
            BSZ_16:  burst_size = 6'd16;
            default: burst_size = 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/dma_len_track.sv
module dma_len_track
    import dma_step_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [1:0]       load_sel,
    input  logic             step,
    output logic [BB_W-1:0]  burst_bytes,
    output logic             done
);
    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [1:0]       sel;
    } len_state_t;

    len_state_t st_d, st_q;
    logic [LEN_W-1:0] size_ext;

    always_comb begin
        size_ext = LEN_W'(burst_size(st_q.sel));
        done     = (st_q.rem == '0);
        if (done)
            burst_bytes = '0;
        else if (st_q.rem < size_ext)
            burst_bytes = BB_W'(st_q.rem);
        else
            burst_bytes = burst_size(st_q.sel);

        st_d = st_q;
        if (load) begin
            st_d.rem = load_len;
            st_d.sel = load_sel;
        end else if (step && !done) begin
            st_d.rem = st_q.rem - LEN_W'(burst_bytes);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (done && burst_bytes == '0));

    // R6
    rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !done) |=> (st_q.rem == $past(st_q.rem) - LEN_W'($past(burst_bytes))));

    // R2
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (burst_bytes != '0 && burst_bytes <= 6'd32));
endmodule

// File: rtl/dma_addr_lane.sv
module dma_addr_lane
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_inc,
    input  logic              load_mem,
    input  logic              load_align,
    input  logic              step,
    input  logic [BB_W-1:0]   step_bytes,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int MEM_LSB = 3;
    localparam int PER_LSB = 2;
    localparam logic [ADDR_W-1:0] MEM_MASK = ~ADDR_W'((1 << MEM_LSB) - 1);
    localparam logic [ADDR_W-1:0] PER_MASK = ~ADDR_W'((1 << PER_LSB) - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              inc;
        logic              mem;
        logic              align;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        if (st_q.align)    addr_out = st_q.addr;
        else if (st_q.mem) addr_out = st_q.addr & MEM_MASK;
        else               addr_out = st_q.addr & PER_MASK;

        st_d = st_q;
        if (load) begin
            st_d.addr  = load_addr;
            st_d.inc   = load_inc;
            st_d.mem   = load_mem;
            st_d.align = load_align;
        end else if (step && st_q.inc) begin
            st_d.addr = st_q.addr + ADDR_W'(step_bytes);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && st_q.inc) |=> (st_q.addr == $past(st_q.addr) + ADDR_W'($past(step_bytes))));

    // R5
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !st_q.inc) |=> $stable(addr_out));

    // R8
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.align && st_q.mem) |-> (addr_out[MEM_LSB-1:0] == '0));

    // R9
    per_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.align && !st_q.mem) |-> (addr_out[PER_LSB-1:0] == '0));
endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] trg_base,
    input  logic              src_step_en,
    input  logic              trg_step_en,
    input  logic              src_is_mem,
    input  logic              trg_is_mem,
    input  logic [1:0]        burst_sel,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              byte_align,
    input  logic              burst_done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] trg_addr,
    output logic [BB_W-1:0]   burst_bytes,
    output logic              done
);
    localparam int NSIDE = 2;

    logic                step_ok;
    logic [ADDR_W-1:0]   base_v [NSIDE];
    logic                inc_v  [NSIDE];
    logic                mem_v  [NSIDE];
    logic [ADDR_W-1:0]   addr_v [NSIDE];

    always_comb begin
        step_ok   = burst_done && !done && !start;
        base_v[0] = src_base;    base_v[1] = trg_base;
        inc_v[0]  = src_step_en; inc_v[1]  = trg_step_en;
        mem_v[0]  = src_is_mem;  mem_v[1]  = trg_is_mem;
        src_addr  = addr_v[0];
        trg_addr  = addr_v[1];
    end

    dma_len_track #(.LEN_W(LEN_W)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .load_len    (xfer_len),
        .load_sel    (burst_sel),
        .step        (step_ok),
        .burst_bytes (burst_bytes),
        .done        (done)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_lane
        dma_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (start),
            .load_addr  (base_v[g]),
            .load_inc   (inc_v[g]),
            .load_mem   (mem_v[g]),
            .load_align (byte_align),
            .step       (step_ok),
            .step_bytes (burst_bytes),
            .addr_out   (addr_v[g])
        );
    end

    // R3
    start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (done == ($past(xfer_len) == '0)));
endmodule

// File: tb/dma_addr_stepper_test.sv
module dma_addr_stepper_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [31:0] src_base = 0, trg_base = 0;
    logic        src_step_en = 0, trg_step_en = 0, src_is_mem = 0, trg_is_mem = 0;
    logic [1:0]  burst_sel = 0;
    logic [12:0] xfer_len = 0;
    logic        byte_align = 0;
    logic        burst_done = 0;
    logic [31:0] src_addr, trg_addr;
    logic [5:0]  burst_bytes;
    logic        done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    dma_addr_stepper uut (.*);

    always #2 clk = ~clk;

    // behavioural reference state
    bit [31:0] m_src, m_trg;
    bit        m_sinc, m_tinc, m_smem, m_tmem, m_align;
    int        m_rem, m_size;

    function automatic int size_of(input logic [1:0] c);
        if (c == 2'b00) return 8;
        if (c == 2'b01) return 16;
        return 32;
    endfunction

    function automatic int cur_bytes();
        if (m_rem == 0) return 0;
        return (m_rem < m_size) ? m_rem : m_size;
    endfunction

    function automatic bit [31:0] shown(input bit [31:0] a, input bit mem, input bit al);
        if (al) return a;
        if (mem) return {a[31:3], 3'b000};
        return {a[31:2], 2'b00};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_trg = 0; m_rem = 0; m_size = 8;
            m_sinc = 0; m_tinc = 0; m_smem = 0; m_tmem = 0; m_align = 0;
        end else if (start) begin
            m_src = src_base; m_trg = trg_base; m_rem = xfer_len;
            m_size = size_of(burst_sel);
            m_sinc = src_step_en; m_tinc = trg_step_en;
            m_smem = src_is_mem; m_tmem = trg_is_mem; m_align = byte_align;
        end else if (burst_done && m_rem != 0) begin
            int b;
            b = cur_bytes();
            if (m_sinc) m_src = m_src + 32'(b);
            if (m_tinc) m_trg = m_trg + 32'(b);
            m_rem = m_rem - b;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit [31:0] es, et;
            es = shown(m_src, m_smem, m_align);
            et = shown(m_trg, m_tmem, m_align);
            check(src_addr == es, "R3/R4/R5/R8/R9/R10/R11/R12 src_addr", src_addr, es);
            check(trg_addr == et, "R3/R4/R5/R8/R9/R10/R11/R12 trg_addr", trg_addr, et);
            check(int'(burst_bytes) == cur_bytes(), "R2/R6 burst_bytes", burst_bytes, cur_bytes());
            check(done == (m_rem == 0), "R6/R7 done", done, m_rem == 0);
        end
    end

    task automatic kick(input bit [31:0] s, input bit [31:0] t, input bit si, input bit ti,
                        input bit sm, input bit tm, input bit [1:0] sel, input int len,
                        input bit al, input bit with_step);
        @(negedge clk);
        src_base = s; trg_base = t; src_step_en = si; trg_step_en = ti;
        src_is_mem = sm; trg_is_mem = tm; burst_sel = sel; xfer_len = 13'(len);
        byte_align = al; start = 1; burst_done = with_step;
        @(negedge clk);
        start = 0; burst_done = 0;
    endtask

    // step until done, scrambling setting inputs to show R12
    task automatic run(input int extra);
        int guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            burst_done = ($urandom_range(0, 3) != 0);
            src_base = $urandom; trg_base = $urandom; xfer_len = 13'($urandom);
            burst_sel = 2'($urandom); byte_align = 1'($urandom);
            src_step_en = 1'($urandom); trg_step_en = 1'($urandom);
            src_is_mem = 1'($urandom); trg_is_mem = 1'($urandom);
            guard++;
        end
        for (int i = 0; i < extra; i++) begin  // R7: strobes while done
            @(negedge clk);
            burst_done = 1;
        end
        @(negedge clk);
        burst_done = 0;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1 && burst_bytes == 0 && src_addr == 0 && trg_addr == 0,
              "R1 reset state", {done, burst_bytes}, 7'h40);
        rst_n = 1;
        @(negedge clk);
        // length shorter than burst
        kick(32'h1000, 32'h2000, 1, 1, 1, 1, 2'b10, 5, 0, 0);
        check(burst_bytes == 5, "R2 short burst", burst_bytes, 5);
        run(3);
        // misaligned, alignment forced
        kick(32'h1003, 32'h2006, 1, 1, 1, 0, 2'b00, 40, 0, 0);
        check(src_addr == 32'h1000, "R8 mem mask", src_addr, 32'h1000);
        check(trg_addr == 32'h2004, "R9 periph mask", trg_addr, 32'h2004);
        run(2);
        // misaligned, byte alignment
        kick(32'h1003, 32'h2006, 1, 1, 1, 0, 2'b01, 37, 1, 0);
        check(src_addr == 32'h1003, "R10 unmasked", src_addr, 32'h1003);
        run(2);
        // only source steps
        kick(32'h4000, 32'h8000_0010, 1, 0, 1, 0, 2'b11, 100, 0, 0);
        run(1);
        // only target steps
        kick(32'h8000_0010, 32'h4000, 0, 1, 0, 1, 2'b01, 50, 0, 0);
        run(1);
        // wrap
        kick(32'hFFFF_FFF0, 32'hFFFF_FFE8, 1, 1, 1, 1, 2'b00, 64, 0, 0);
        run(1);
        check(src_addr == 32'h30, "R11 wrap", src_addr, 32'h30);
        // zero length
        kick(32'h10, 32'h20, 1, 1, 1, 1, 2'b00, 0, 0, 0);
        check(done == 1, "R6 zero length", done, 1);
        // start with simultaneous step: start wins
        kick(32'h100, 32'h200, 1, 1, 1, 1, 2'b00, 24, 0, 0);
        @(negedge clk); burst_done = 1;
        kick(32'h500, 32'h600, 1, 1, 1, 1, 2'b00, 24, 0, 1);
        check(src_addr == 32'h500 && burst_bytes == 8, "R3 start priority", src_addr, 32'h500);
        run(1);
        // long transfer
        kick(32'h0, 32'h10_0000, 1, 1, 1, 1, 2'b00, 8191, 0, 0);
        run(2);
        for (int k = 0; k < 30; k++) begin
            kick($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), int'($urandom_range(0, 300)), 1'($urandom), 1'($urandom));
            run(int'($urandom_range(0, 3)));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule